// File: doc/BRIEF.md
# Multiplexed Segment LCD Drive Sequencer

This block produces the common and segment drive sequences for a passive segment LCD with four common lines and thirty-two segment lines. Each output is a 2-bit voltage-level code that an external analog stage turns into the real voltage. The codes are 0 = VSS, 1 = V2, 2 = V1 and 3 = VLCD. Common k sits on `com_lvl[2k+1:2k]` and segment i (0..31) on `seg_lvl[2i+1:2i]`. The duty (three or four commons scanned) and the bias (1/2 or 1/3) are chosen at run time. The four highest segments (indices 28..31) can each become a plain logic output.

A host writes 8-bit words MSB first on a serial data line. Bits are sampled on rising edges of the serial clock while the active-low chip select is low. The serial pins are oversampled in the block clock domain. Internally the received words form a valid-only stream with no ready signal: a serial source cannot be stalled, so every completed word is consumed in the cycle it appears. The data has to settle only at frame boundaries. A clock-enable tick paces the scan. An active-low blanking input forces the display to the non-select state.

Top module: `lcd_mux_drv`

## Requirements
- R1: While `rst_n` is low, and with no tick after its release, the block clears to the following state. Duty is three commons, bias is 1/2 and all logic-output enables are off. The output latch holds zeros. Polarity is normal and common 0 is selected. So `com_lvl` = 8'hAB and every segment code is 2.
- R2: A word is taken only while `cs_n` is low. It is 8 bits long, MSB first, with one bit sampled per rising edge of `sck`. Serial clock edges while `cs_n` is high have no effect.
- R3: The first word after `cs_n` falls is the command. If its bit 7 is 0, bits 4:0 give the start segment address. Each later word of that transfer writes its bits 3:0 to the current segment, where bit k set means the segment is on in common slot k. The address then increments, wrapping from 31 to 0.
- R4: A command word with bit 7 = 1 sets the mode. Bit 0 selects the duty (1 = four commons, 0 = three). Bit 1 selects the bias (1 = 1/3, 0 = 1/2). Bits 5:2 enable logic-output mode for segments 28..31. Later words of that transfer are ignored.
- R5: With ticks, each common stays selected for TPS ticks, in the order 0, 1, 2(, 3). In three-common duty, common 3 is never selected. Exactly one common drives an extreme level while the display is on.
- R6: In a normal-polarity frame the levels are as follows. The selected common is 3. An unselected common is 1 (1/3 bias) or 2 (1/2 bias). An on segment is 0 and an off segment is 2. In an inverted frame the levels are as follows. The selected common is 0 and an unselected common is 2. An on segment is 3, and an off segment is 1 (1/3 bias) or 2 (1/2 bias).
- R7: The polarity inverts at every frame boundary, that is, every time the scan returns to common 0.
- R8: Written display data reaches the outputs only at a frame boundary. A write in mid-frame leaves the outputs unchanged until the next frame.
- R9: While `blank_n` is low, every common and every non-logic segment drives code 0.
- R10: A segment in logic-output mode drives 3 or 0 from bit 0 of its display data. It takes a new value only when the scan enters common slot 0. It keeps that value while `blank_n` is low.
- R11: Without `tick_i` the scan position and polarity hold, so all outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Scan clock enable |
| cs_n | input | 1 | Active-low serial chip select |
| sck | input | 1 | Serial clock, sampled in the `clk` domain |
| sdi | input | 1 | Serial data, MSB first |
| blank_n | input | 1 | Active-low display blanking |
| com_lvl | output | 8 | Common level codes, 2 bits per common |
| seg_lvl | output | 64 | Segment level codes, 2 bits per segment |

## Verification
The checker assumes the following about the inputs:
- `sck`, `sdi` and `cs_n` each stay stable for at least three `clk` cycles between changes, so that every serial edge is seen once after synchronisation.
- `tick_i` is a single-cycle-wide enable per clock, which holds for any level.

The bench drives each serial bit phase for three clocks and opens and closes chip select with three-clock guards. It stops the tick only between clock edges. Mode changes are applied only outside the windows in which the common-selection and polarity properties are evaluated for a given pattern.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

  typedef enum logic [1:0] {
    LV_VSS  = 2'd0,
    LV_V2   = 2'd1,
    LV_V1   = 2'd2,
    LV_VLCD = 2'd3
  } lvl_e;

  typedef enum logic [0:0] {
    WS_DATA = 1'b0,
    WS_SKIP = 1'b1
  } wstate_e;

  // Common line: selected line swings to an extreme, others to a mid level.
  function automatic lvl_e com_code(input logic sel, input logic pol, input logic bias3);
    if (sel) return pol ? LV_VSS : LV_VLCD;
    return (pol || !bias3) ? LV_V1 : LV_V2;
  endfunction

  // Segment line: on drives the opposite extreme, off a mid level.
  function automatic lvl_e seg_code(input logic on, input logic pol, input logic bias3);
    if (on) return pol ? LV_VLCD : LV_VSS;
    return (!pol || !bias3) ? LV_V1 : LV_V2;
  endfunction

endpackage

// File: rtl/lcd_serial_rx.sv
module lcd_serial_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sck,
  input  logic         sdi,
  output logic         wr_valid,
  output logic [W-1:0] wr_data,
  output logic         wr_first
);
  localparam int CW = $clog2(W);

  logic [1:0]    cs_sync, sck_sync, sdi_sync;
  logic          sck_prev;
  logic [W-1:0]  shreg;
  logic [CW-1:0] bitcnt;
  logic          first_pend;
  logic          sck_rise;
  logic [W-1:0]  next_word;

  assign sck_rise  = sck_sync[1] && !sck_prev;
  assign next_word = {shreg[W-2:0], sdi_sync[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sync  <= 2'b11;
      sck_sync <= 2'b00;
      sdi_sync <= 2'b00;
      sck_prev <= 1'b0;
    end else begin
      cs_sync  <= {cs_sync[0], cs_n};
      sck_sync <= {sck_sync[0], sck};
      sdi_sync <= {sdi_sync[0], sdi};
      sck_prev <= sck_sync[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      bitcnt     <= '0;
      first_pend <= 1'b1;
      wr_valid   <= 1'b0;
      wr_data    <= '0;
      wr_first   <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      if (cs_sync[1]) begin
        bitcnt     <= '0;
        first_pend <= 1'b1;
      end else if (sck_rise) begin
        shreg  <= next_word;
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == CW'(W - 1)) begin
          wr_valid   <= 1'b1;
          wr_data    <= next_word;
          wr_first   <= first_pend;
          first_pend <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/lcd_cmd_regs.sv
module lcd_cmd_regs
  import lcd_pkg::*;
#(
  parameter int W     = 8,
  parameter int N_COM = 4,
  parameter int N_SEG = 32,
  parameter int N_GP  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  input  logic [W-1:0]           wr_data,
  input  logic                   wr_first,
  output logic                   duty4,
  output logic                   bias3,
  output logic [N_GP-1:0]        gp_en,
  output logic [N_SEG*N_COM-1:0] dreg_flat
);
  localparam int AW = $clog2(N_SEG);

  logic [N_COM-1:0] dreg [N_SEG];
  logic [AW-1:0]    addr;
  wstate_e          wst;
  logic             unused_bit;

  assign unused_bit = wr_data[W-2];

  for (genvar i = 0; i < N_SEG; i++) begin : g_flat
    assign dreg_flat[i*N_COM +: N_COM] = dreg[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty4 <= 1'b0;
      bias3 <= 1'b0;
      gp_en <= '0;
      addr  <= '0;
      wst   <= WS_SKIP;
      for (int i = 0; i < N_SEG; i++) dreg[i] <= '0;
    end else if (wr_valid) begin
      if (wr_first) begin
        if (wr_data[W-1]) begin
          duty4 <= wr_data[0];
          bias3 <= wr_data[1];
          gp_en <= wr_data[2 +: N_GP];
          wst   <= WS_SKIP;
        end else begin
          addr <= wr_data[AW-1:0];
          wst  <= WS_DATA;
        end
      end else if (wst == WS_DATA) begin
        dreg[addr] <= wr_data[N_COM-1:0];
        addr       <= addr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcd_scan.sv
module lcd_scan #(
  parameter int N_COM = 4,
  parameter int TPS   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic                     duty4,
  output logic [$clog2(N_COM)-1:0] com_idx,
  output logic                     pol,
  output logic                     frame_start
);
  localparam int CIW = $clog2(N_COM);
  localparam int CW  = (TPS > 1) ? $clog2(TPS) : 1;

  logic [CW-1:0]  tcnt;
  logic [CIW-1:0] last_com;
  logic           slot_end;

  assign last_com    = duty4 ? CIW'(N_COM - 1) : CIW'(N_COM - 2);
  assign slot_end    = tick && (tcnt == CW'(TPS - 1));
  assign frame_start = slot_end && (com_idx >= last_com);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt    <= '0;
      com_idx <= '0;
      pol     <= 1'b0;
    end else if (tick) begin
      if (slot_end) begin
        tcnt <= '0;
        if (frame_start) begin
          com_idx <= '0;
          pol     <= ~pol;
        end else begin
          com_idx <= com_idx + 1'b1;
        end
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcd_out_stage.sv
module lcd_out_stage
  import lcd_pkg::*;
#(
  parameter int N_COM = 4,
  parameter int N_SEG = 32,
  parameter int N_GP  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_start,
  input  logic [N_SEG*N_COM-1:0]   dreg_flat,
  input  logic                     bias3,
  input  logic [N_GP-1:0]          gp_en,
  input  logic [$clog2(N_COM)-1:0] com_idx,
  input  logic                     pol,
  input  logic                     blank_n,
  output logic [2*N_COM-1:0]       com_lvl,
  output logic [2*N_SEG-1:0]       seg_lvl
);
  localparam int GP_BASE = N_SEG - N_GP;

  logic [N_SEG*N_COM-1:0] latch_q;
  logic [N_GP-1:0]        gp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      gp_q    <= '0;
    end else if (frame_start) begin
      latch_q <= dreg_flat;
      for (int j = 0; j < N_GP; j++) gp_q[j] <= dreg_flat[(GP_BASE + j) * N_COM];
    end
  end

  for (genvar k = 0; k < N_COM; k++) begin : g_com
    assign com_lvl[2*k +: 2] = blank_n ? com_code(com_idx == k, pol, bias3) : LV_VSS;
  end

  for (genvar i = 0; i < N_SEG; i++) begin : g_seg
    logic [N_COM-1:0] nib;
    lvl_e             disp_lvl;
    assign nib      = latch_q[i*N_COM +: N_COM];
    assign disp_lvl = blank_n ? seg_code(nib[com_idx], pol, bias3) : LV_VSS;
    if (i >= GP_BASE) begin : g_gp
      assign seg_lvl[2*i +: 2] = gp_en[i-GP_BASE] ? (gp_q[i-GP_BASE] ? LV_VLCD : LV_VSS)
                                                   : disp_lvl;
    end else begin : g_plain
      assign seg_lvl[2*i +: 2] = disp_lvl;
    end
  end
endmodule

// File: rtl/lcd_mux_drv.sv
module lcd_mux_drv #(
  parameter int N_COM = 4,
  parameter int N_SEG = 32,
  parameter int N_GP  = 4,
  parameter int TPS   = 4,
  parameter int W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               cs_n,
  input  logic               sck,
  input  logic               sdi,
  input  logic               blank_n,
  output logic [2*N_COM-1:0] com_lvl,
  output logic [2*N_SEG-1:0] seg_lvl
);
  localparam int CIW = $clog2(N_COM);

  logic                   wr_valid, wr_first;
  logic [W-1:0]           wr_data;
  logic                   duty4, bias3;
  logic [N_GP-1:0]        gp_en;
  logic [N_SEG*N_COM-1:0] dreg_flat;
  logic [CIW-1:0]         com_idx;
  logic                   pol, frame_start;

  lcd_serial_rx #(.W(W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_first(wr_first)
  );

  lcd_cmd_regs #(.W(W), .N_COM(N_COM), .N_SEG(N_SEG), .N_GP(N_GP)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_first(wr_first), .duty4(duty4), .bias3(bias3), .gp_en(gp_en),
    .dreg_flat(dreg_flat)
  );

  lcd_scan #(.N_COM(N_COM), .TPS(TPS)) u_scan (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .duty4(duty4),
    .com_idx(com_idx), .pol(pol), .frame_start(frame_start)
  );

  lcd_out_stage #(.N_COM(N_COM), .N_SEG(N_SEG), .N_GP(N_GP)) u_out (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .dreg_flat(dreg_flat),
    .bias3(bias3), .gp_en(gp_en), .com_idx(com_idx), .pol(pol),
    .blank_n(blank_n), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );
endmodule

// File: rtl/lcd_mux_chk.sv
module lcd_mux_chk #(
  parameter int N_COM = 4,
  parameter int N_SEG = 32,
  parameter int N_GP  = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     blank_n,
  input logic [2*N_COM-1:0]       com_lvl,
  input logic [2*N_SEG-1:0]       seg_lvl,
  input logic                     frame_start,
  input logic [$clog2(N_COM)-1:0] com_idx,
  input logic                     pol,
  input logic [N_GP-1:0]          gp_en
);
  localparam int GP_BASE = N_SEG - N_GP;

  logic [N_COM-1:0] extreme;
  for (genvar k = 0; k < N_COM; k++) begin : g_ext
    assign extreme[k] = (com_lvl[2*k +: 2] == 2'b00) || (com_lvl[2*k +: 2] == 2'b11);
  end

  a_r9_blank_commons: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |-> (com_lvl == '0));

  a_r5_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    blank_n |-> ($countones(extreme) == 1));

  a_r7_polarity_flip: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (pol != $past(pol)));

  a_r5_wrap_first: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (com_idx == '0));

  for (genvar j = 0; j < N_GP; j++) begin : g_gp
    a_r10_gp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (gp_en[j] && !frame_start) |=>
        (!gp_en[j] || $stable(seg_lvl[2*(GP_BASE+j) +: 2])));
    a_r10_gp_logic: assert property (@(posedge clk) disable iff (!rst_n)
      gp_en[j] |-> (seg_lvl[2*(GP_BASE+j) +: 2] == 2'b00 ||
                    seg_lvl[2*(GP_BASE+j) +: 2] == 2'b11));
  end
endmodule

bind lcd_mux_drv lcd_mux_chk #(.N_COM(N_COM), .N_SEG(N_SEG), .N_GP(N_GP)) u_chk (
  .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .com_lvl(com_lvl),
  .seg_lvl(seg_lvl), .frame_start(frame_start), .com_idx(com_idx),
  .pol(pol), .gp_en(gp_en)
);

// File: tb/sim_lcd_mux_drv.sv
module sim_lcd_mux_drv;
  localparam int N_COM = 4;
  localparam int N_SEG = 32;
  localparam int N_GP  = 4;
  localparam int TPS   = 4;
  localparam int GPB   = N_SEG - N_GP;
  localparam int FRAME = N_COM * TPS;
  // {mode word, pattern seed}
  localparam logic [15:0] VEC [6] = '{16'h80_13, 16'h81_25, 16'h82_37,
                                      16'h83_49, 16'h87_5B, 16'hBF_6D};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, tick_en, cs_n, sck, sdi, blank_n;
  logic [2*N_COM-1:0] com_lvl;
  logic [2*N_SEG-1:0] seg_lvl;

  lcd_mux_drv #(.N_COM(N_COM), .N_SEG(N_SEG), .N_GP(N_GP), .TPS(TPS)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_en), .cs_n(cs_n), .sck(sck),
    .sdi(sdi), .blank_n(blank_n), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [N_COM-1:0] mdata [N_SEG];
  logic m_duty4, m_bias3;
  logic [N_GP-1:0] m_gp, m_gpval;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2*N_COM-1:0] e_com(input int sel, input bit pol, input bit blank);
    logic [2*N_COM-1:0] r;
    for (int k = 0; k < N_COM; k++) begin
      if (blank) r[2*k +: 2] = 2'd0;
      else if (k == sel) r[2*k +: 2] = pol ? 2'd0 : 2'd3;
      else r[2*k +: 2] = (pol || !m_bias3) ? 2'd2 : 2'd1;
    end
    return r;
  endfunction

  function automatic logic [2*N_SEG-1:0] e_seg(input int sel, input bit pol, input bit blank);
    logic [2*N_SEG-1:0] r;
    for (int i = 0; i < N_SEG; i++) begin
      if (i >= GPB && m_gp[i-GPB]) r[2*i +: 2] = m_gpval[i-GPB] ? 2'd3 : 2'd0;
      else if (blank) r[2*i +: 2] = 2'd0;
      else if (mdata[i][sel]) r[2*i +: 2] = pol ? 2'd3 : 2'd0;
      else r[2*i +: 2] = (!pol || !m_bias3) ? 2'd2 : 2'd1;
    end
    return r;
  endfunction

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdi = b[i];
      repeat (3) @(negedge clk);
      sck = 1'b1;
      repeat (3) @(negedge clk);
      sck = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic xfer_open();
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic xfer_close();
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic write_mode(input logic [7:0] b);
    xfer_open(); send_byte(b); xfer_close();
    m_duty4 = b[0]; m_bias3 = b[1]; m_gp = b[5:2];
  endtask

  task automatic write_all(input logic [7:0] start);
    xfer_open();
    send_byte(start);
    for (int n = 0; n < N_SEG; n++) send_byte({4'h0, mdata[(int'(start) + n) % N_SEG]});
    xfer_close();
  endtask

  task automatic fill(input logic [7:0] seed);
    for (int i = 0; i < N_SEG; i++) mdata[i] = 4'((i * seed + (i >> 2)) ^ seed);
  endtask

  task automatic settle();
    repeat (3 * FRAME + 4) @(negedge clk);
    for (int j = 0; j < N_GP; j++) m_gpval[j] = mdata[GPB+j][0];
  endtask

  task automatic decode(output int sel, output bit pol, output bit ok);
    int n = 0;
    sel = -1; pol = 0;
    for (int k = 0; k < N_COM; k++) begin
      if (com_lvl[2*k +: 2] == 2'd0 || com_lvl[2*k +: 2] == 2'd3) begin
        n++; sel = k; pol = (com_lvl[2*k +: 2] == 2'd0);
      end
    end
    ok = (n == 1);
  endtask

  task automatic check_frame(input string req);
    int sel, prev = -1;
    bit pol, ok, have = 0, last_pol = 0, seen3 = 0;
    for (int c = 0; c < 2 * FRAME; c++) begin
      @(negedge clk);
      decode(sel, pol, ok);
      check(ok, "R5 single selected common", 64'(com_lvl), 64'(0));
      if (ok) begin
        check(com_lvl == e_com(sel, pol, 0), "R6 common levels", 64'(com_lvl), 64'(e_com(sel, pol, 0)));
        check(seg_lvl == e_seg(sel, pol, 0), req, seg_lvl, e_seg(sel, pol, 0));
        if (sel == 0 && prev != 0) begin
          if (have) check(pol != last_pol, "R7 polarity flip", 64'(pol), 64'(!last_pol));
          have = 1; last_pol = pol;
        end
        if (sel == N_COM - 1) seen3 = 1;
        prev = sel;
      end
    end
    check(seen3 == m_duty4, "R5 duty common count", 64'(seen3), 64'(m_duty4));
  endtask

  task automatic check_reset(input string tag);
    check(com_lvl == 8'hAB, {"R1 reset commons ", tag}, 64'(com_lvl), 64'hAB);
    check(seg_lvl == {N_SEG{2'b10}}, {"R1 reset segments ", tag}, seg_lvl, {N_SEG{2'b10}});
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    logic [2*N_SEG-1:0] snap_s;
    logic [2*N_COM-1:0] snap_c;
    int sel;
    bit pol, ok;
    rst_n = 0; tick_en = 0; cs_n = 1; sck = 0; sdi = 0; blank_n = 1;
    m_duty4 = 0; m_bias3 = 0; m_gp = '0; m_gpval = '0;
    for (int i = 0; i < N_SEG; i++) mdata[i] = '0;
    repeat (4) @(negedge clk);
    check_reset("held");
    rst_n = 1;
    repeat (3) @(negedge clk);
    check_reset("released no tick");
    tick_en = 1;

    // Table of mode/pattern vectors (R3 R4 R5 R6 R7 R10)
    for (int v = 0; v < 6; v++) begin
      write_mode(VEC[v][15:8]);
      fill(VEC[v][7:0]);
      write_all(8'h00);
      settle();
      check_frame("R3 R6 R10 segment levels");
    end

    // R3 address wrap: start at 31, next word lands on 0
    write_mode(8'h83);
    fill(8'h21);
    write_all(8'h1F);
    settle();
    check_frame("R3 address wrap");

    // R4 words after a mode command are ignored
    xfer_open(); send_byte(8'h81); send_byte(8'h0F); send_byte(8'h0A); xfer_close();
    m_duty4 = 1; m_bias3 = 0; m_gp = '0;
    settle();
    check_frame("R4 trailing words ignored");

    // R2 serial clocks with chip select high do nothing
    send_byte(8'h00); send_byte(8'hFF); send_byte(8'h8E);
    settle();
    check_frame("R2 cs high ignored");

    // R8 R11 mid-frame write frozen, then released
    tick_en = 0;
    @(negedge clk);
    snap_s = seg_lvl; snap_c = com_lvl;
    fill(8'h5A);
    write_all(8'h00);
    check(seg_lvl == snap_s, "R8 no mid-frame update", seg_lvl, snap_s);
    check(com_lvl == snap_c, "R11 scan holds without tick", 64'(com_lvl), 64'(snap_c));
    tick_en = 1;
    settle();
    check_frame("R8 data after frame boundary");

    // R9 R10 blanking and logic outputs
    write_mode(8'hBF);
    settle();
    blank_n = 0;
    repeat (2) @(negedge clk);
    check(com_lvl == '0, "R9 blank commons", 64'(com_lvl), 64'(0));
    check(seg_lvl == e_seg(0, 0, 1), "R9 R10 blank segments", seg_lvl, e_seg(0, 0, 1));
    blank_n = 1;

    // R10 logic output changes only on entry to common slot 0
    for (int g = 0; g < 200; g++) begin
      @(negedge clk);
      decode(sel, pol, ok);
      if (ok && sel == 1) break;
    end
    tick_en = 0;
    mdata[GPB] = mdata[GPB] ^ 4'h1;
    xfer_open(); send_byte(8'(GPB)); send_byte({4'h0, mdata[GPB]}); xfer_close();
    check(seg_lvl[2*GPB +: 2] == {2{m_gpval[0]}}, "R10 gp held mid-frame",
          64'(seg_lvl[2*GPB +: 2]), 64'({2{m_gpval[0]}}));
    tick_en = 1;
    for (int g = 0; g < 200; g++) begin
      @(negedge clk);
      decode(sel, pol, ok);
      if (ok && sel == 0) break;
      check(seg_lvl[2*GPB +: 2] == {2{m_gpval[0]}}, "R10 gp before slot 0",
            64'(seg_lvl[2*GPB +: 2]), 64'({2{m_gpval[0]}}));
    end
    m_gpval[0] = mdata[GPB][0];
    check(seg_lvl[2*GPB +: 2] == {2{m_gpval[0]}}, "R10 gp at slot 0",
          64'(seg_lvl[2*GPB +: 2]), 64'({2{m_gpval[0]}}));

    // R1 reset mid-run clears mode and latch
    @(negedge clk);
    rst_n = 0; tick_en = 0;
    repeat (2) @(negedge clk);
    check_reset("mid-run");
    rst_n = 1;
    repeat (2) @(negedge clk);
    check_reset("after mid-run release");

    finish_run();
  end
endmodule